// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs the refill of a single cache line after a read miss. The fill begins at the word that missed rather than at word zero, and the remaining words are then requested in ascending order that wraps around the end of the line. The missed word is handed to the processor on the beat it returns from memory, and the stall is released in that same cycle. The rest of the line keeps arriving in the background while the processor runs.

Each word of the line has its own valid flag, so a partly filled line can be told apart from a complete one. A later processor read that targets the line being filled is answered at once if its word has already landed. If the word has not landed, the read stalls until the word arrives and is answered on that arrival beat. A one-cycle completion pulse marks the end of the fill. Tag lookup, victim choice and writes belong to the surrounding cache.

Top module: `cwf_line_fill`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `mem_req`, `cpu_stall`, `line_done` and every bit of `word_valid` are 0.
- R2: A miss is accepted when `miss_valid` is high and `busy` is low. From the next cycle, `mem_req` is high and `mem_addr` equals the miss address with bits [1:0] cleared. The missed word index is `miss_addr[4:2]`.
- R3: From acceptance until the first data beat, `cpu_stall` is high. On the first beat, `cpu_rvalid` is high, `cpu_rdata` equals `mem_rdata` and `cpu_stall` is low, all in that same cycle. During the later beats `cpu_stall` stays low when there is no processor read.
- R4: Beat k (k = 0 to 7) of a fill is requested at line base + 4·((critical index + k) mod 8).
- R5: The requested address changes only after a cycle with `mem_rvalid` high. While `mem_rvalid` is low, `mem_addr` holds its value.
- R6: Bit i of `word_valid` becomes 1 in the cycle after word i arrives. Before beat k, exactly the k words already fetched are marked valid.
- R7: A processor read (`cpu_rd`, word index `cpu_word`) of a word that is already valid returns that word in the same cycle with `cpu_stall` low. A read of a word not yet valid keeps `cpu_stall` high until the beat that carries the word, and is answered with `mem_rdata` in that beat.
- R8: In the cycle after the eighth beat, `line_done` is high for exactly one cycle. In that cycle all bits of `word_valid` are 1 and `busy` is 0.
- R9: While `busy` is high, `miss_accept` stays low and a presented miss has no effect on the address sequence of the fill in progress.
- R10: Accepting a new miss clears all `word_valid` bits, so words of the previous line no longer satisfy processor reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Read miss presented for refill |
| miss_addr | input | AW | Byte address of the missed word |
| miss_accept | output | 1 | Miss taken this cycle |
| mem_req | output | 1 | Word request to lower memory active |
| mem_addr | output | AW | Word-aligned address being requested |
| mem_rvalid | input | 1 | Data beat strobe from memory |
| mem_rdata | input | DW | Data beat from memory |
| cpu_rd | input | 1 | Processor read of the line being filled |
| cpu_word | input | log2(WORDS) | Word index of that read |
| cpu_rvalid | output | 1 | Read data valid to processor |
| cpu_rdata | output | DW | Read data to processor |
| cpu_stall | output | 1 | Processor must wait |
| word_valid | output | WORDS | Per-word landed flags |
| line_done | output | 1 | One-cycle fill-complete pulse |
| busy | output | 1 | Fill in progress |

## Verification
Two functions can fall in one cycle. A processor read can wait on a word while the memory beat carrying that word arrives, so forwarding and the line-buffer write coincide. A new miss can also be presented while a fill is still running. The first case is provoked by holding a read on a word two positions ahead of the fill pointer and judging that the answer appears, with memory data and the stall dropped, exactly on the arrival beat. The second is provoked by presenting a foreign miss mid-fill and judging that it is refused and that the remaining addresses still follow the original line's wrapped order.

// File: rtl/cwf_line_fill.sv
`timescale 1ns/1ps
module cwf_line_fill #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  input  logic [AW-1:0]            miss_addr,
  output logic                     miss_accept,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_rvalid,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     cpu_rd,
  input  logic [$clog2(WORDS)-1:0] cpu_word,
  output logic                     cpu_rvalid,
  output logic [DW-1:0]            cpu_rdata,
  output logic                     cpu_stall,
  output logic [WORDS-1:0]         word_valid,
  output logic                     line_done,
  output logic                     busy
);
  localparam int OFF = $clog2(WORDS);
  localparam int BO  = $clog2(DW/8);
  localparam int TW  = AW - OFF - BO;

  logic            busy_q, crit_q, done_q;
  logic [TW-1:0]   base_q;
  logic [OFF-1:0]  ptr_q, cnt_q;
  logic [WORDS-1:0] vld_q;
  logic [DW-1:0]   line_q [WORDS];

  wire beat    = busy_q && mem_rvalid;
  wire last    = beat && (cnt_q == OFF'(WORDS-1));
  wire arrives = beat && (ptr_q == cpu_word);

  assign miss_accept = miss_valid && !busy_q;
  assign mem_req     = busy_q;
  assign mem_addr    = {base_q, ptr_q, {BO{1'b0}}};
  assign busy        = busy_q;
  assign word_valid  = vld_q;
  assign line_done   = done_q;

  assign cpu_rvalid = crit_q ? beat
                             : (cpu_rd && (vld_q[cpu_word] || arrives));
  assign cpu_rdata  = (crit_q || (arrives && !vld_q[cpu_word])) ? mem_rdata
                                                                : line_q[cpu_word];
  assign cpu_stall  = (crit_q && !beat) || (!crit_q && cpu_rd && !cpu_rvalid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      crit_q <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
    end else begin
      done_q <= last;
      if (miss_accept) begin
        base_q <= miss_addr[AW-1:OFF+BO];
        ptr_q  <= miss_addr[BO +: OFF];
        cnt_q  <= '0;
        vld_q  <= '0;
        busy_q <= 1'b1;
        crit_q <= 1'b1;
      end else if (beat) begin
        vld_q[ptr_q] <= 1'b1;
        ptr_q  <= ptr_q + 1'b1;
        cnt_q  <= cnt_q + 1'b1;
        crit_q <= 1'b0;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (beat) line_q[ptr_q] <= mem_rdata;
  end

  assert_first_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_accept |=> (mem_req && mem_addr == {$past(miss_addr[AW-1:BO]), {BO{1'b0}}}));

  assert_early_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_q) && mem_rvalid) |-> (cpu_rvalid && !cpu_stall && cpu_rdata == mem_rdata));

  assert_wrap_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mem_rvalid && !last) |=>
      (mem_addr[BO +: OFF] == OFF'($past(mem_addr[BO +: OFF]) + 1'b1)));

  assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mem_rvalid) |=> $stable(mem_addr));

  assert_valid_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !crit_q && word_valid[cpu_word]) |-> (cpu_rvalid && !cpu_stall));

  assert_done_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (&word_valid && !busy && $past(mem_rvalid)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miss_accept);
endmodule

// File: tb/cwf_line_fill_tb.sv
`timescale 1ns/1ps
module cwf_line_fill_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_accept, mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cpu_rd = 1'b0;
  logic [2:0]  cpu_word = '0;
  logic        cpu_rvalid, cpu_stall, line_done, busy;
  logic [31:0] cpu_rdata;
  logic [7:0]  word_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cwf_line_fill u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_accept(miss_accept), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cpu_rd(cpu_rd),
    .cpu_word(cpu_word), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .word_valid(word_valid), .line_done(line_done),
    .busy(busy)
  );

  localparam int NV = 6;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_0000, 32'h0000_101C, 32'h0000_2A54,
                                         32'h8000_0068, 32'hFFFF_FFE8, 32'h1234_5678};
  localparam int          V_GAP  [NV] = '{0, 1, 0, 2, 3, 1};
  localparam logic [2:0]  V_CRIT [NV] = '{3'd0, 3'd7, 3'd5, 3'd2, 3'd2, 3'd6};

  function automatic logic [31:0] model(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
  endfunction

  function automatic logic [7:0] mask_of(input logic [2:0] c, input int k);
    logic [7:0] m = '0;
    for (int j = 0; j < k; j++) m[3'(c + 3'(j))] = 1'b1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic accept_miss(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    #1 chk(miss_accept === 1'b1, "R2 accept", 32'(miss_accept), 32'd1);
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    chk(word_valid === 8'h00, "R10 valid cleared", 32'(word_valid), 32'h0);
    chk(mem_req === 1'b1 && mem_addr === {a[31:2], 2'b00}, "R2 first addr",
        mem_addr, {a[31:2], 2'b00});
    chk(cpu_stall === 1'b1, "R3 stall before beat", 32'(cpu_stall), 32'd1);
  endtask

  task automatic drive_beat(input int gap, output logic [31:0] a, output logic [31:0] d);
    logic [31:0] a0;
    @(negedge clk);
    mem_rvalid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      a0 = mem_addr;
      @(negedge clk);
      chk(mem_addr === a0, "R5 hold addr", mem_addr, a0);
    end
    a = mem_addr;
    d = model(a);
    mem_rvalid = 1'b1;
    mem_rdata  = d;
    #1;
  endtask

  task automatic finish_line();
    @(negedge clk);
    mem_rvalid = 1'b0;
    #1;
    chk(line_done === 1'b1, "R8 done pulse", 32'(line_done), 32'd1);
    chk(word_valid === 8'hFF, "R8 all valid", 32'(word_valid), 32'hFF);
    chk(busy === 1'b0, "R8 not busy", 32'(busy), 32'd0);
    @(negedge clk);
    #1 chk(line_done === 1'b0, "R8 pulse one cycle", 32'(line_done), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a, d, base, ea;
    logic [2:0]  c;

    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0 && mem_req === 1'b0, "R1 reset busy", {busy, mem_req}, 32'd0);
    chk(cpu_stall === 1'b0 && line_done === 1'b0, "R1 reset stall", {cpu_stall, line_done}, 32'd0);
    chk(word_valid === 8'h00, "R1 reset valid", 32'(word_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk(busy === 1'b0 && word_valid === 8'h00, "R1 after reset", 32'(word_valid), 32'h0);

    for (int v = 0; v < NV; v++) begin
      accept_miss(V_ADDR[v]);
      c    = V_ADDR[v][4:2];
      base = {V_ADDR[v][31:5], 5'b0};
      for (int k = 0; k < 8; k++) begin
        drive_beat(V_GAP[v], a, d);
        ea = base + 32'((3'(c + 3'(k))) * 4);
        chk(a === ea, "R4 wrap order", a, ea);
        chk(word_valid === mask_of(c, k), "R6 valid bits", 32'(word_valid), 32'(mask_of(c, k)));
        if (k == 0) begin
          chk(a[4:2] === V_CRIT[v], "R2 critical index", 32'(a[4:2]), 32'(V_CRIT[v]));
          chk(cpu_rvalid === 1'b1 && cpu_stall === 1'b0 && cpu_rdata === d,
              "R3 forward and release", cpu_rdata, d);
        end else begin
          chk(cpu_stall === 1'b0, "R3 cpu runs during fill", 32'(cpu_stall), 32'd0);
        end
      end
      finish_line();
    end

    // Reads during a fill, foreign miss, and collision of forwarding with arrival
    accept_miss(32'h0000_1234);
    base = 32'h0000_1220;
    drive_beat(0, a, d);
    chk(a === base + 32'd20, "R2 word 5 first", a, base + 32'd20);
    @(negedge clk);
    mem_rvalid = 1'b0;
    cpu_rd = 1'b1;
    cpu_word = 3'd5;
    #1 chk(cpu_rvalid === 1'b1 && cpu_stall === 1'b0 && cpu_rdata === model(base + 32'd20),
           "R7 valid word hit", cpu_rdata, model(base + 32'd20));
    cpu_word = 3'd7;
    miss_valid = 1'b1;
    miss_addr = 32'h0000_9000;
    #0.5;
    chk(cpu_rvalid === 1'b0 && cpu_stall === 1'b1, "R7 pending word stalls", 32'(cpu_stall), 32'd1);
    chk(miss_accept === 1'b0, "R9 miss refused", 32'(miss_accept), 32'd0);
    drive_beat(0, a, d);
    miss_valid = 1'b0;
    chk(a === base + 32'd24, "R9 sequence unchanged", a, base + 32'd24);
    chk(cpu_stall === 1'b1, "R7 still waiting", 32'(cpu_stall), 32'd1);
    drive_beat(0, a, d);
    chk(a === base + 32'd28, "R4 word 7", a, base + 32'd28);
    chk(cpu_rvalid === 1'b1 && cpu_stall === 1'b0 && cpu_rdata === d,
        "R7 served on arrival beat", cpu_rdata, d);
    cpu_rd = 1'b0;
    for (int k = 3; k < 8; k++) begin
      drive_beat(1, a, d);
      ea = base + 32'((3'(3'd5 + 3'(k))) * 4);
      chk(a === ea, "R9 original line continues", a, ea);
    end
    finish_line();

    // New miss clears old words
    accept_miss(32'h0000_4000);
    cpu_rd = 1'b1;
    cpu_word = 3'd5;
    #0.5 chk(cpu_rvalid === 1'b0 && cpu_stall === 1'b1, "R10 old word not served",
             32'(cpu_rvalid), 32'd0);
    cpu_rd = 1'b0;
    for (int k = 0; k < 8; k++) begin
      drive_beat(0, a, d);
      chk(a === 32'h0000_4000 + 32'(k * 4), "R4 from word 0", a, 32'h0000_4000 + 32'(k * 4));
    end
    finish_line();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule